// File: doc/BRIEF.md
# Address-Mapped NAND Flash Bus Adapter

This block connects a simple request/acknowledge host bus to one 8-bit raw NAND flash device. Software reaches the flash through a small address window. The low address bits of each byte access pick the NAND control lines that are active for that access:

- one bit raises the address latch;
- one bit raises the command latch;
- one bit asserts chip enable;
- one bit asserts the spare-area enable;
- one bit asserts write protect.

A command byte is therefore a write with the chip-enable and command-latch bits set. An address byte uses chip enable with the address latch. Data bytes use chip enable alone.

Each flash access runs through a fixed sequence of phases, each with its own length:

- an optional setup cycle;
- a write or read strobe whose length depends on the direction;
- a hold phase;
- a recovery phase.

The host is acknowledged on the last hold cycle. A second region of the host map holds a control register, a status register and a timing register. The status register reports the synchronised ready/busy line of the flash and a sticky access-complete flag, so a driver can poll after every command or address byte.

Top module: `nand_bus_adapter`

## Requirements
- R1: Host address bit 7 = 0 selects the flash window. During the setup, strobe and hold phases of an access, the pins follow the latched address bits: bit 2 drives the address latch, bit 3 the command latch, bit 4 chip enable, bit 5 spare enable and bit 6 write protect. The command and address latches are active high.
- R2: Each access runs through the following phases, then returns to idle:
  - setup: 1 cycle if timing bit 0 is set, otherwise skipped;
  - strobe: wait+1 cycles, where the read wait is timing bits 6:4 and the write wait is bits 10:8;
  - hold: max(1, timing bits 13:12) cycles;
  - recovery: timing bits 17:16 cycles.
  The one-cycle host acknowledge comes on the last hold cycle. The timing register resets to setup on, read wait 2, write wait 2, hold 1, recovery 1.
- R3: On a flash read, the byte on the flash data input is captured on the last strobe cycle only. It is returned in host read data bits 7:0 with the acknowledge.
- R4: On a flash write, the data output enable is high from setup through hold and low otherwise. The data output carries the host write byte.
- R5: Status bit 3 (access complete) is 0 after reset. It clears when an access starts and sets when the access ends (end of recovery, or end of hold when recovery is 0).
- R6: Status bit 0 is the ready/busy input of chip 0, or of chip 1 when control bit 8 is set, passed through two flip-flops. A host status read captures the register on the clock edge that follows the request.
- R7: Control bits 4, 5 and 6 set the active level of chip enable, spare enable and write protect (0 = active low, 1 = active high). Control bit 10 routes chip enable to the chip-1 output instead of chip 0. The chip-enable output that is not selected stays inactive.
- R8: With control bit 0 (flash mode) and bit 20 (force enable) both set, the selected chip enable is active while idle. Clearing both releases it.
- R9: With flash mode (control bit 0) clear, a flash-window access is acknowledged on the next cycle with read data 0 and no strobe on either strobe pin.
- R10: Host address bit 7 = 1 selects registers, with bits 3:2 choosing control (0), status (1) or timing (2). Register accesses are acknowledged on the next cycle. Control and timing writes read back, with the unused control bits reading 0. Any request made while a flash access or a register acknowledge is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Byte address (bit 7 selects registers) |
| host_wdata | input | 32 | Write data (bits 7:0 for flash bytes) |
| host_rdata | output | 32 | Read data, valid with host_ack |
| host_ack | output | 1 | One-cycle completion pulse |
| nand_ce_o | output | 2 | Chip enables for chip 0 and chip 1 |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_wp_o | output | 1 | Write protect |
| nand_se_o | output | 1 | Spare area enable |
| nand_dq_o | output | 8 | Flash data out |
| nand_dq_oe_o | output | 1 | Flash data output enable |
| nand_dq_i | input | 8 | Flash data in |
| nand_rb_i | input | 2 | Ready/busy of chip 0 and chip 1 |

## Verification
The bench counts falling edges after the request cycle to place each result:

- With S the setup bit, W the selected wait and H the effective hold, the acknowledge is due at count S+W+1+H.
- The strobe starts at count S+1 and lasts W+1 counts.
- The output enable spans counts 1 to S+W+1+H on writes.

The bench drives the flash input with the true byte only in the cycle of the last strobe, so the capture point is fixed to that cycle. Register reads are due one count after the request. The ready/busy check places a status read on the edge where only the first synchroniser stage has the new level, and a second read two edges later where the new level must appear.

// File: rtl/nba_pkg.sv
package nba_pkg;

    localparam int HOST_AW  = 8;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 32;
    localparam int WAIT_W   = 3;
    localparam int PHASE_W  = 2;
    localparam int NUM_CS   = 2;
    localparam int CNT_W    = (WAIT_W > PHASE_W) ? WAIT_W : PHASE_W;

    // flash-window address bits that select pins
    localparam int ADR_ALE  = 2;
    localparam int ADR_CLE  = 3;
    localparam int ADR_CS   = 4;
    localparam int ADR_SE   = 5;
    localparam int ADR_WP   = 6;

    // control register bit positions
    localparam int CB_EN    = 0;
    localparam int CB_MUX   = 1;
    localparam int CB_CSP   = 4;
    localparam int CB_SEP   = 5;
    localparam int CB_WPP   = 6;
    localparam int CB_PREP  = 7;
    localparam int CB_INCS  = 8;
    localparam int CB_OUTCS = 10;
    localparam int CB_CEF   = 20;

    // timing register field bases
    localparam int TB_SETUP = 0;
    localparam int TB_RD    = 4;
    localparam int TB_WR    = 8;
    localparam int TB_HOLD  = 12;
    localparam int TB_REC   = 16;

    // status bits and register selects
    localparam int ST_RB    = 0;
    localparam int ST_DONE  = 3;
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_TIM  = 2'd2;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_RECOV, PH_BYPASS
    } phase_e;

    typedef struct packed {
        logic nand_en;
        logic cs_mux;
        logic cs_pol;
        logic se_pol;
        logic wp_pol;
        logic pre_pol;
        logic in_cs1;
        logic out_cs1;
        logic ce_force;
    } ctrl_t;

    typedef struct packed {
        logic               setup_en;
        logic [WAIT_W-1:0]  rd_wait;
        logic [WAIT_W-1:0]  wr_wait;
        logic [PHASE_W-1:0] hold;
        logic [PHASE_W-1:0] recov;
    } timing_t;

    typedef struct packed {
        logic              wr;
        logic              ale;
        logic              cle;
        logic              cs;
        logic              se;
        logic              wp;
        logic [BYTE_W-1:0] wdata;
    } access_t;

    localparam timing_t TIM_RESET = '{setup_en: 1'b1,
                                      rd_wait:  WAIT_W'(2),
                                      wr_wait:  WAIT_W'(2),
                                      hold:     PHASE_W'(1),
                                      recov:    PHASE_W'(1)};

    function automatic access_t decode_access(input logic [HOST_AW-1:0] a,
                                              input logic wr,
                                              input logic [BYTE_W-1:0] d);
        access_t r;
        r.wr    = wr;
        r.ale   = a[ADR_ALE];
        r.cle   = a[ADR_CLE];
        r.cs    = a[ADR_CS];
        r.se    = a[ADR_SE];
        r.wp    = a[ADR_WP];
        r.wdata = d;
        return r;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.nand_en  = w[CB_EN];
        c.cs_mux   = w[CB_MUX];
        c.cs_pol   = w[CB_CSP];
        c.se_pol   = w[CB_SEP];
        c.wp_pol   = w[CB_WPP];
        c.pre_pol  = w[CB_PREP];
        c.in_cs1   = w[CB_INCS];
        c.out_cs1  = w[CB_OUTCS];
        c.ce_force = w[CB_CEF];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ctrl(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[CB_EN]    = c.nand_en;
        w[CB_MUX]   = c.cs_mux;
        w[CB_CSP]   = c.cs_pol;
        w[CB_SEP]   = c.se_pol;
        w[CB_WPP]   = c.wp_pol;
        w[CB_PREP]  = c.pre_pol;
        w[CB_INCS]  = c.in_cs1;
        w[CB_OUTCS] = c.out_cs1;
        w[CB_CEF]   = c.ce_force;
        return w;
    endfunction

    function automatic timing_t unpack_timing(input logic [WORD_W-1:0] w);
        timing_t t;
        t.setup_en = w[TB_SETUP];
        t.rd_wait  = w[TB_RD +: WAIT_W];
        t.wr_wait  = w[TB_WR +: WAIT_W];
        t.hold     = w[TB_HOLD +: PHASE_W];
        t.recov    = w[TB_REC +: PHASE_W];
        return t;
    endfunction

    function automatic logic [WORD_W-1:0] pack_timing(input timing_t t);
        logic [WORD_W-1:0] w;
        w                     = '0;
        w[TB_SETUP]           = t.setup_en;
        w[TB_RD +: WAIT_W]    = t.rd_wait;
        w[TB_WR +: WAIT_W]    = t.wr_wait;
        w[TB_HOLD +: PHASE_W] = t.hold;
        w[TB_REC +: PHASE_W]  = t.recov;
        return w;
    endfunction

    // active level of a pin given its polarity bit (0 = active low)
    function automatic logic pin_level(input logic active, input logic pol);
        return pol ? active : ~active;
    endfunction

endpackage

// File: rtl/nba_regs.sv
module nba_regs
    import nba_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_tim,
    input  logic [WORD_W-1:0] wdata,
    input  logic [NUM_CS-1:0] rb_in,
    input  logic              done,
    output ctrl_t             ctrl,
    output timing_t           tim,
    output logic [WORD_W-1:0] status
);

    logic [SYNC_STAGES-1:0] rb_sync;
    logic                   rb_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            tim  <= TIM_RESET;
        end else begin
            if (wr_ctrl) ctrl <= unpack_ctrl(wdata);
            if (wr_tim)  tim  <= unpack_timing(wdata);
        end
    end

    assign rb_raw = rb_in[ctrl.in_cs1];

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) rb_sync[g] <= 1'b0;
                else     rb_sync[g] <= (g == 0) ? rb_raw : rb_sync[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    always_comb begin
        status          = '0;
        status[ST_RB]   = rb_sync[SYNC_STAGES-1];
        status[ST_DONE] = done;
    end

endmodule

// File: rtl/nba_seq.sv
module nba_seq
    import nba_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  access_t           acc_in,
    input  logic              nand_en,
    input  timing_t           tim,
    input  logic [BYTE_W-1:0] dq_in,
    output phase_e            phase,
    output access_t           acc,
    output logic              ack,
    output logic [BYTE_W-1:0] rdata,
    output logic              done
);

    logic [CNT_W-1:0] cnt;
    logic             cnt_last;

    function automatic logic [CNT_W-1:0] strobe_len(input timing_t t, input logic wr);
        return CNT_W'(wr ? t.wr_wait : t.rd_wait);
    endfunction

    function automatic logic [CNT_W-1:0] hold_len(input timing_t t);
        return (t.hold == '0) ? '0 : CNT_W'(t.hold - PHASE_W'(1));
    endfunction

    assign cnt_last = (cnt == '0);
    assign ack      = ((phase == PH_HOLD) && cnt_last) || (phase == PH_BYPASS);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            acc   <= '0;
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        acc   <= acc_in;
                        rdata <= '0;
                        done  <= 1'b0;
                        if (!nand_en) begin
                            phase <= PH_BYPASS;
                        end else if (tim.setup_en) begin
                            phase <= PH_SETUP;
                        end else begin
                            phase <= PH_STROBE;
                            cnt   <= strobe_len(tim, acc_in.wr);
                        end
                    end
                end
                PH_SETUP: begin
                    phase <= PH_STROBE;
                    cnt   <= strobe_len(tim, acc.wr);
                end
                PH_STROBE: begin
                    if (cnt_last) begin
                        if (!acc.wr) rdata <= dq_in;
                        phase <= PH_HOLD;
                        cnt   <= hold_len(tim);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_HOLD: begin
                    if (cnt_last) begin
                        if (tim.recov == '0) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            phase <= PH_RECOV;
                            cnt   <= CNT_W'(tim.recov - PHASE_W'(1));
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_RECOV: begin
                    if (cnt_last) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_BYPASS: begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack) else $error("ack longer than one cycle"); // R2

    AST_DONE_CLEARS_ON_START: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start) |=> !done) else $error("done not cleared"); // R5

    AST_STROBE_TO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE) |=> (phase == PH_STROBE || phase == PH_HOLD))
        else $error("strobe left to wrong phase"); // R2

    AST_DONE_RISE_AT_END: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(phase) == PH_HOLD || $past(phase) == PH_RECOV
                         || $past(phase) == PH_BYPASS))
        else $error("done rose mid access"); // R5

endmodule

// File: rtl/nba_pins.sv
module nba_pins
    import nba_pkg::*;
(
    input  ctrl_t             ctrl,
    input  access_t           acc,
    input  phase_e            phase,
    output logic [NUM_CS-1:0] ce,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic              wp,
    output logic              se,
    output logic [BYTE_W-1:0] dq_out,
    output logic              dq_oe
);

    logic busy;
    logic strobe;
    logic cs_act;

    assign busy   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    assign strobe = (phase == PH_STROBE);
    assign cs_act = ctrl.nand_en && (ctrl.ce_force || (busy && acc.cs));

    assign cle    = busy && acc.cle;
    assign ale    = busy && acc.ale;
    assign we_n   = !(strobe && acc.wr);
    assign re_n   = !(strobe && !acc.wr);
    assign se     = pin_level(busy && acc.se, ctrl.se_pol);
    assign wp     = pin_level(busy && acc.wp, ctrl.wp_pol);
    assign dq_oe  = busy && acc.wr;
    assign dq_out = acc.wdata;

    generate
        for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
            assign ce[i] = pin_level(cs_act && (32'(ctrl.out_cs1) == i), ctrl.cs_pol);
        end
    endgenerate

endmodule

// File: rtl/nand_bus_adapter.sv
module nand_bus_adapter
    import nba_pkg::*;
#(
    parameter int ADDR_W = HOST_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              host_ack,
    output logic [NUM_CS-1:0] nand_ce_o,
    output logic              nand_cle_o,
    output logic              nand_ale_o,
    output logic              nand_we_n_o,
    output logic              nand_re_n_o,
    output logic              nand_wp_o,
    output logic              nand_se_o,
    output logic [BYTE_W-1:0] nand_dq_o,
    output logic              nand_dq_oe_o,
    input  logic [BYTE_W-1:0] nand_dq_i,
    input  logic [NUM_CS-1:0] nand_rb_i
);

    localparam int REG_BIT = ADDR_W - 1;

    ctrl_t             ctrl;
    timing_t           tim;
    logic [WORD_W-1:0] status;
    phase_e            phase;
    access_t           acc;
    logic              seq_ack;
    logic [BYTE_W-1:0] seq_rdata;
    logic              done;

    logic              accept;
    logic              reg_hit;
    logic [1:0]        reg_sel;
    logic              reg_ack_q;
    logic [WORD_W-1:0] reg_rdata_q;
    logic              nand_start;

    assign accept     = host_req && (phase == PH_IDLE) && !reg_ack_q;
    assign reg_hit    = host_addr[REG_BIT];
    assign reg_sel    = host_addr[3:2];
    assign nand_start = accept && !reg_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_ack_q   <= 1'b0;
            reg_rdata_q <= '0;
        end else begin
            reg_ack_q <= accept && reg_hit;
            if (accept && reg_hit) begin
                unique case (reg_sel)
                    SEL_CTRL: reg_rdata_q <= pack_ctrl(ctrl);
                    SEL_STAT: reg_rdata_q <= status;
                    SEL_TIM:  reg_rdata_q <= pack_timing(tim);
                    default:  reg_rdata_q <= '0;
                endcase
            end
        end
    end

    nba_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (accept && reg_hit && host_wr && reg_sel == SEL_CTRL),
        .wr_tim  (accept && reg_hit && host_wr && reg_sel == SEL_TIM),
        .wdata   (host_wdata),
        .rb_in   (nand_rb_i),
        .done    (done),
        .ctrl    (ctrl),
        .tim     (tim),
        .status  (status)
    );

    nba_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (nand_start),
        .acc_in  (decode_access(HOST_AW'(host_addr), host_wr, host_wdata[BYTE_W-1:0])),
        .nand_en (ctrl.nand_en),
        .tim     (tim),
        .dq_in   (nand_dq_i),
        .phase   (phase),
        .acc     (acc),
        .ack     (seq_ack),
        .rdata   (seq_rdata),
        .done    (done)
    );

    nba_pins u_pins (
        .ctrl   (ctrl),
        .acc    (acc),
        .phase  (phase),
        .ce     (nand_ce_o),
        .cle    (nand_cle_o),
        .ale    (nand_ale_o),
        .we_n   (nand_we_n_o),
        .re_n   (nand_re_n_o),
        .wp     (nand_wp_o),
        .se     (nand_se_o),
        .dq_out (nand_dq_o),
        .dq_oe  (nand_dq_oe_o)
    );

    assign host_ack   = seq_ack || reg_ack_q;
    assign host_rdata = seq_ack ? {{(WORD_W-BYTE_W){1'b0}}, seq_rdata} : reg_rdata_q;

    AST_STROBE_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n_o || !nand_re_n_o) |-> ctrl.nand_en)
        else $error("strobe with flash mode off"); // R9

    AST_OE_NOT_ON_READ: assert property (@(posedge clk) disable iff (rst)
        nand_dq_oe_o |-> nand_re_n_o) else $error("driving during read strobe"); // R4

    AST_NO_DOUBLE_ACK: assert property (@(posedge clk) disable iff (rst)
        !(seq_ack && reg_ack_q)) else $error("two acks at once"); // R10

endmodule

// File: tb/nand_bus_adapter_tb.sv
module nand_bus_adapter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ack;
    logic [1:0]  nand_ce_o;
    logic        nand_cle_o, nand_ale_o, nand_we_n_o, nand_re_n_o;
    logic        nand_wp_o, nand_se_o, nand_dq_oe_o;
    logic [7:0]  nand_dq_o;
    logic [7:0]  nand_dq_i = '0;
    logic [1:0]  nand_rb_i = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    nand_bus_adapter dut_i (
        .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ack(host_ack), .nand_ce_o(nand_ce_o), .nand_cle_o(nand_cle_o),
        .nand_ale_o(nand_ale_o), .nand_we_n_o(nand_we_n_o), .nand_re_n_o(nand_re_n_o),
        .nand_wp_o(nand_wp_o), .nand_se_o(nand_se_o), .nand_dq_o(nand_dq_o),
        .nand_dq_oe_o(nand_dq_oe_o), .nand_dq_i(nand_dq_i), .nand_rb_i(nand_rb_i)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_addr = {1'b1, 3'b0, sel, 2'b0}; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        chk(host_ack === 1'b1, "R10 reg write ack", host_ack, 1);
        @(negedge clk);
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b0; host_addr = {1'b1, 3'b0, sel, 2'b0};
        @(negedge clk);
        host_req = 1'b0;
        chk(host_ack === 1'b1, "R10 reg read ack", host_ack, 1);
        d = host_rdata;
        @(negedge clk);
    endtask

    // one flash access, observed count by count after the request cycle
    task automatic flash_access(input logic [4:0] pat, input bit wr, input logic [7:0] byt,
                                input int s, input int w, input int h, input int r,
                                input bit csp, input bit sep, input bit wpp, input bit outcs);
        int hh, ack_exp, ack_k, st_first, st_cnt, oe_cnt, oe_bad;
        logic [7:0] got;
        logic [1:0] ce_seen;
        logic cle_s, ale_s, se_s, wp_s;
        logic [1:0] ce_exp;
        hh = (h == 0) ? 1 : h;
        ack_exp = s + w + 1 + hh;
        ack_k = -1; st_first = -1; st_cnt = 0; oe_cnt = 0; oe_bad = 0; got = '0;
        ce_seen = '0; cle_s = 0; ale_s = 0; se_s = 0; wp_s = 0;
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = {1'b0, pat, 2'b00};
        host_wdata = {24'h0, byt};
        nand_dq_i = ~byt;
        for (int k = 1; k <= ack_exp + r + 2; k++) begin
            @(negedge clk);
            host_req = 1'b0;
            nand_dq_i = (k == s + w + 1) ? byt : ~byt;
            if (!nand_we_n_o || !nand_re_n_o) begin
                if (st_first < 0) begin
                    st_first = k;
                    ce_seen = nand_ce_o; cle_s = nand_cle_o; ale_s = nand_ale_o;
                    se_s = nand_se_o; wp_s = nand_wp_o;
                end
                st_cnt++;
                if (wr == nand_we_n_o) oe_bad++;
            end
            if (nand_dq_oe_o) begin
                oe_cnt++;
                if (nand_dq_o !== byt || k > ack_exp) oe_bad++;
            end
            if (host_ack && ack_k < 0) begin
                ack_k = k;
                got = host_rdata[7:0];
            end
        end
        chk(ack_k == ack_exp, "R2 ack count", ack_k, ack_exp);
        chk(st_first == s + 1, "R2 strobe start", st_first, s + 1);
        chk(st_cnt == w + 1, "R2 strobe length", st_cnt, w + 1);
        chk(oe_cnt == (wr ? ack_exp : 0) && oe_bad == 0, "R4 data drive window",
            oe_cnt, wr ? ack_exp : 0);
        ce_exp[outcs]  = pat[2] ? csp : ~csp;
        ce_exp[~outcs] = ~csp;
        chk(cle_s == pat[1] && ale_s == pat[0], "R1 latch pins",
            {cle_s, ale_s}, {pat[1], pat[0]});
        chk(ce_seen == ce_exp, "R1 R7 chip enable", ce_seen, ce_exp);
        chk(se_s == (pat[3] ? sep : ~sep) && wp_s == (pat[4] ? wpp : ~wpp),
            "R1 R7 spare/protect", {se_s, wp_s}, {(pat[3] ? sep : ~sep), (pat[4] ? wpp : ~wpp)});
        if (!wr) chk(got == byt, "R3 read capture", got, byt);
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected done", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int idx;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(host_ack === 1'b0 && nand_we_n_o && nand_re_n_o && !nand_dq_oe_o,
            "R2 reset idle pins", {host_ack, nand_we_n_o, nand_re_n_o}, 3'b011);
        chk(nand_ce_o === 2'b11, "R8 ce idle after reset", nand_ce_o, 2'b11);
        reg_read(2'd2, d);
        chk(d == 32'h0001_1221, "R2 timing reset", d, 32'h0001_1221);
        reg_read(2'd1, d);
        chk(d[3] == 1'b0, "R5 done reset", d[3], 0);
        reg_read(2'd0, d);
        chk(d == 0, "R10 ctrl reset", d, 0);

        // R9: flash mode off
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b0; host_addr = 8'h10; nand_dq_i = 8'hA5;
        @(negedge clk);
        host_req = 1'b0;
        chk(host_ack === 1'b1 && host_rdata == 0, "R9 bypass ack data", host_rdata, 0);
        chk(nand_re_n_o && nand_we_n_o, "R9 no strobe", {nand_we_n_o, nand_re_n_o}, 2'b11);
        @(negedge clk);
        chk(nand_re_n_o && nand_we_n_o && !host_ack, "R9 still no strobe",
            {host_ack, nand_re_n_o}, 2'b01);

        // R10 readback with unused bits masked
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_read(2'd0, d);
        chk(d == 32'h0010_05F3, "R10 ctrl readback", d, 32'h0010_05F3);

        // R8 forced enable
        reg_write(2'd0, 32'h0010_0001);
        chk(nand_ce_o == 2'b10, "R8 forced ce", nand_ce_o, 2'b10);
        reg_write(2'd0, 32'h0);
        chk(nand_ce_o == 2'b11, "R8 released ce", nand_ce_o, 2'b11);

        // sweep of timing, direction, pin pattern and polarity
        idx = 0;
        for (int s = 0; s < 2; s++)
          for (int w = 0; w < 4; w++)
            for (int h = 0; h < 3; h++)
              for (int r = 0; r < 3; r++)
                for (int dir = 0; dir < 2; dir++) begin
                    logic [31:0] t, c;
                    logic [4:0] pat;
                    int we;
                    we = dir ? (3 - w) : w;
                    t = s | (w << 4) | ((3 - w) << 8) | (h << 12) | (r << 16);
                    c = 1 | ((idx & 1) << 4) | (((idx >> 1) & 1) << 5) |
                        (((idx >> 2) & 1) << 6) | (((idx >> 3) & 1) << 10);
                    pat = 5'((idx * 5 + 4) % 32);
                    reg_write(2'd2, t);
                    reg_write(2'd0, c);
                    flash_access(pat, dir[0], 8'((idx * 37 + 11) & 8'hFF), s, we, h, r,
                                 c[4], c[5], c[6], c[10]);
                    if (idx % 16 == 0) begin
                        reg_read(2'd1, d);
                        chk(d[3] == 1'b1, "R5 done after access", d[3], 1);
                    end
                    idx++;
                end

        // R10 request during recovery is ignored
        reg_write(2'd0, 32'h1);
        reg_write(2'd2, 32'h0002_1221);
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_addr = 8'h18; host_wdata = 32'h3C;
        while (!host_ack) begin
            @(negedge clk);
            host_req = 1'b0;
        end
        host_req = 1'b1; host_wr = 1'b1; host_addr = 8'h88; host_wdata = 32'h0;
        @(negedge clk);
        host_req = 1'b0;
        chk(host_ack === 1'b0, "R10 ignored no ack", host_ack, 0);
        repeat (3) @(negedge clk);
        reg_read(2'd2, d);
        chk(d == 32'h0002_1221, "R10 timing untouched", d, 32'h0002_1221);
        reg_read(2'd1, d);
        chk(d[3] == 1'b1, "R5 done after recovery", d[3], 1);

        // R6 ready/busy synchroniser and input select
        nand_rb_i = 2'b01;
        reg_read(2'd1, d);
        chk(d[0] == 1'b0, "R6 one stage only", d[0], 0);
        reg_read(2'd1, d);
        chk(d[0] == 1'b1, "R6 after two stages", d[0], 1);
        reg_write(2'd0, 32'h0000_0101);
        repeat (3) @(negedge clk);
        reg_read(2'd1, d);
        chk(d[0] == 1'b0, "R6 chip1 select", d[0], 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule